// File: doc/BRIEF.md
# Differential Sensor Scan Sequencer

This block is the digital sequencer for a capacitive sensing array with a set of drive columns and an even number of sense rows, where the rows are read in pairs by half as many shared differential integrators. A frame is started by a one-cycle request. The sequencer first discharges every cell. It then visits the columns one at a time in ascending order. Each column is read twice. The first read pairs neighbouring rows starting at row 0. The second read shifts the pairing by one row, and its last pair wraps from the top row back to row 0. A pair whose cells match cancels in one read, but it is resolved by the other.

Each read begins with an integrator reset. A programmable number of drive-then-sense integration steps follows. The comparator codes for all integrators are then stored in one word, in one of two frame memories chosen by the read. The analog array, integrators and comparators sit outside the block. The block provides their switch controls, the per-integrator row selection and the memory write port.

Top module: `diff_scan_seq`

## Requirements
- R1: After reset, every control output, the write strobe, `busy_o` and `frame_done_o` are low. `col_o` and `pair_sel_o` are 0.
- R2: A `start_i` pulse while idle begins a frame. `cell_rst_o` is then high for `CRST_CYC` consecutive cycles, starting the cycle after the pulse, and no drive occurs before that window ends.
- R3: Columns are scanned in ascending order from 0 to `NUM_COLS-1`. Each column is read with `pair_sel_o`=0 (first read) and then with `pair_sel_o`=1 (second read).
- R4: When `pair_sel_o`=0, integrator k has its positive input on row 2k and its negative input on row 2k+1.
- R5: When `pair_sel_o`=1, integrator k has its positive input on row 2k+1 and its negative input on row 2k+2. The last integrator takes row `NUM_ROWS-1` and row 0.
- R6: Each read starts with a one-cycle `amp_rst_o` pulse, which comes before the read's first drive. It contains exactly N sense steps. N is `int_count_i`, sampled at the accepted start, and a value of 0 gives N=1.
- R7: `calib_o` is low in every drive cycle and high in every sense cycle.
- R8: `drive_en_o` and `sense_en_o` are never high in the same cycle. In the cycle right after either one is high, the other is low.
- R9: The cycle after the last sense of a read, `mem_we_o` is high for one cycle. In that cycle `mem_data_o` equals `cmp_code_i`, with integrator k's code in bits [2k+1:2k]. Code 00 means equal cells, 01 means positive valley/negative ridge, and 10 means positive ridge/negative valley. `mem_col_o` is the column, and `mem_bank_o` is 0 for the first read and 1 for the second.
- R10: `frame_done_o` is a one-cycle pulse in the cycle after the final write (second read of the last column). `busy_o` is low from the following cycle.
- R11: A `start_i` pulse while `busy_o` is high has no effect: no extra writes and no restart of the column order.
- R12: A change of `int_count_i` during a frame does not change the step count of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request pulse |
| int_count_i | input | CNT_W | Integration steps per read (0 acts as 1) |
| cmp_code_i | input | 2*NUM_ROWS/2 | Comparator codes, 2 bits per integrator |
| cell_rst_o | output | 1 | Discharge all cells |
| drive_en_o | output | 1 | Drive the selected column |
| sense_en_o | output | 1 | Share cell charge onto the integrators |
| amp_rst_o | output | 1 | Return integrators to common mode |
| calib_o | output | 1 | Integrator accumulate enable |
| pair_sel_o | output | 1 | Row pairing: 0 straight, 1 shifted |
| col_o | output | COL_W | Selected drive column |
| pos_row_o | output | NUM_ROWS/2*ROW_W | Positive-input row index per integrator |
| neg_row_o | output | NUM_ROWS/2*ROW_W | Negative-input row index per integrator |
| mem_we_o | output | 1 | Frame memory write strobe |
| mem_bank_o | output | 1 | 0: frame memory 1, 1: frame memory 2 |
| mem_col_o | output | COL_W | Write address (column) |
| mem_data_o | output | 2*NUM_ROWS/2 | Codes of all integrators |
| busy_o | output | 1 | Frame in progress |
| frame_done_o | output | 1 | Frame complete pulse |

## Verification
The case hardest to reach from the ports is the signal-cancellation case. In that case every pair in one read gives 00, and only the shifted read with its wrap-around pair shows the edges. The bench models the array as ridge/valley patterns that are computed per frame, and its comparator model follows the row indices the block drives. One pattern uses uniform rows with a single odd row, so that the wrap pair and the zero-code reads are both exercised. The bench also pulses `start_i` and changes `int_count_i` in the middle of a frame. It then checks that the order of writes and the number of sense steps per read stay the same as they were when the frame started.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CRST,
    ST_ARST,
    ST_DRV,
    ST_GAP_DS,
    ST_SNS,
    ST_GAP_SD,
    ST_CAPT,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/dss_pair_map.sv
module dss_pair_map #(
  parameter int NUM_ROWS = 16,
  localparam int NUM_INT = NUM_ROWS / 2,
  localparam int ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic                     pair_sel_i,
  output logic [NUM_INT*ROW_W-1:0] pos_row_o,
  output logic [NUM_INT*ROW_W-1:0] neg_row_o
);
  for (genvar k = 0; k < NUM_INT; k++) begin : g_int
    localparam int P0 = 2 * k;
    localparam int N0 = 2 * k + 1;
    localparam int P1 = 2 * k + 1;
    localparam int N1 = (k == NUM_INT - 1) ? 0 : 2 * k + 2;
    assign pos_row_o[k*ROW_W +: ROW_W] = pair_sel_i ? ROW_W'(P1) : ROW_W'(P0);
    assign neg_row_o[k*ROW_W +: ROW_W] = pair_sel_i ? ROW_W'(N1) : ROW_W'(N0);
  end
endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
#(
  parameter int NUM_COLS = 20,
  parameter int CRST_CYC = 2,
  parameter int CNT_W    = 4,
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int RC_W    = $clog2(CRST_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] int_count_i,
  output logic             cell_rst_o,
  output logic             drive_en_o,
  output logic             sense_en_o,
  output logic             amp_rst_o,
  output logic             calib_o,
  output logic             pair_sel_o,
  output logic [COL_W-1:0] col_o,
  output logic             capt_o,
  output logic             busy_o,
  output logic             frame_done_o
);
  seq_state_e       state_q, state_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             phase_q, phase_d;
  logic [CNT_W-1:0] step_q, step_d;
  logic [CNT_W-1:0] nint_q, nint_d;
  logic [RC_W-1:0]  rcnt_q, rcnt_d;

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    phase_d = phase_q;
    step_d  = step_q;
    nint_d  = nint_q;
    rcnt_d  = rcnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CRST;
        rcnt_d  = '0;
        col_d   = '0;
        phase_d = 1'b0;
        nint_d  = (int_count_i == '0) ? CNT_W'(1) : int_count_i;
      end
      ST_CRST: begin
        if (rcnt_q == RC_W'(CRST_CYC - 1)) state_d = ST_ARST;
        else rcnt_d = rcnt_q + 1'b1;
      end
      ST_ARST: begin
        state_d = ST_DRV;
        step_d  = '0;
      end
      ST_DRV:    state_d = ST_GAP_DS;
      ST_GAP_DS: state_d = ST_SNS;
      ST_SNS: begin
        if (step_q == nint_q - 1'b1) state_d = ST_CAPT;
        else begin
          state_d = ST_GAP_SD;
          step_d  = step_q + 1'b1;
        end
      end
      ST_GAP_SD: state_d = ST_DRV;
      ST_CAPT: begin
        if (!phase_q) begin
          phase_d = 1'b1;
          state_d = ST_ARST;
        end else if (col_q == COL_W'(NUM_COLS - 1)) begin
          state_d = ST_DONE;
        end else begin
          col_d   = col_q + 1'b1;
          phase_d = 1'b0;
          state_d = ST_ARST;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      phase_q <= 1'b0;
      step_q  <= '0;
      nint_q  <= CNT_W'(1);
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      phase_q <= phase_d;
      step_q  <= step_d;
      nint_q  <= nint_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign cell_rst_o   = (state_q == ST_CRST);
  assign drive_en_o   = (state_q == ST_DRV);
  assign sense_en_o   = (state_q == ST_SNS);
  assign calib_o      = (state_q == ST_SNS);
  assign amp_rst_o    = (state_q == ST_ARST);
  assign capt_o       = (state_q == ST_CAPT);
  assign frame_done_o = (state_q == ST_DONE);
  assign busy_o       = (state_q != ST_IDLE);
  assign pair_sel_o   = phase_q;
  assign col_o        = col_q;

  // R8
  drv_sns_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drive_en_o && sense_en_o));
  // R8
  drv_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_o |=> !sense_en_o);
  // R8
  sns_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_en_o |=> !drive_en_o);
  // R9
  capt_after_sns_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(capt_o) |-> $past(sense_en_o));
  // R2
  crst_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cell_rst_o) |-> $past(!busy_o && start_i));
  // R10
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(capt_o && pair_sel_o && col_o == COL_W'(NUM_COLS - 1)));
  // R6
  arst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_rst_o |=> drive_en_o);
endmodule

// File: rtl/diff_scan_seq.sv
module diff_scan_seq #(
  parameter int NUM_COLS = 20,
  parameter int NUM_ROWS = 16,
  parameter int CRST_CYC = 2,
  parameter int CNT_W    = 4,
  localparam int NUM_INT = NUM_ROWS / 2,
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int CODE_W  = 2 * NUM_INT
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         int_count_i,
  input  logic [CODE_W-1:0]        cmp_code_i,
  output logic                     cell_rst_o,
  output logic                     drive_en_o,
  output logic                     sense_en_o,
  output logic                     amp_rst_o,
  output logic                     calib_o,
  output logic                     pair_sel_o,
  output logic [COL_W-1:0]         col_o,
  output logic [NUM_INT*ROW_W-1:0] pos_row_o,
  output logic [NUM_INT*ROW_W-1:0] neg_row_o,
  output logic                     mem_we_o,
  output logic                     mem_bank_o,
  output logic [COL_W-1:0]         mem_col_o,
  output logic [CODE_W-1:0]        mem_data_o,
  output logic                     busy_o,
  output logic                     frame_done_o
);
  logic capt;

  dss_ctrl #(
    .NUM_COLS (NUM_COLS),
    .CRST_CYC (CRST_CYC),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .int_count_i  (int_count_i),
    .cell_rst_o   (cell_rst_o),
    .drive_en_o   (drive_en_o),
    .sense_en_o   (sense_en_o),
    .amp_rst_o    (amp_rst_o),
    .calib_o      (calib_o),
    .pair_sel_o   (pair_sel_o),
    .col_o        (col_o),
    .capt_o       (capt),
    .busy_o       (busy_o),
    .frame_done_o (frame_done_o)
  );

  dss_pair_map #(
    .NUM_ROWS (NUM_ROWS)
  ) u_map (
    .pair_sel_i (pair_sel_o),
    .pos_row_o  (pos_row_o),
    .neg_row_o  (neg_row_o)
  );

  assign mem_we_o   = capt;
  assign mem_bank_o = pair_sel_o;
  assign mem_col_o  = col_o;
  assign mem_data_o = capt ? cmp_code_i : '0;

  // R9
  we_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
endmodule

// File: tb/sim_diff_scan_seq.sv
module sim_diff_scan_seq;
  localparam int NC = 4;
  localparam int NR = 6;
  localparam int CR = 2;
  localparam int NI = NR / 2;
  localparam int CW = $clog2(NC);
  localparam int RW = $clog2(NR);

  typedef struct packed {
    logic          bank;
    logic [CW-1:0] col;
    logic [2*NI-1:0] data;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] icnt = '0;
  logic [2*NI-1:0] cmp;
  logic cell_rst, drv, sns, arst, cal, psel, we, bank, busy, done;
  logic [CW-1:0] col, mcol;
  logic [NI*RW-1:0] prow, nrow;
  logic [2*NI-1:0] mdata;

  always #2ns clk = ~clk;

  diff_scan_seq #(.NUM_COLS(NC), .NUM_ROWS(NR), .CRST_CYC(CR), .CNT_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .int_count_i(icnt),
    .cmp_code_i(cmp), .cell_rst_o(cell_rst), .drive_en_o(drv), .sense_en_o(sns),
    .amp_rst_o(arst), .calib_o(cal), .pair_sel_o(psel), .col_o(col),
    .pos_row_o(prow), .neg_row_o(nrow), .mem_we_o(we), .mem_bank_o(bank),
    .mem_col_o(mcol), .mem_data_o(mdata), .busy_o(busy), .frame_done_o(done)
  );

  int n_chk = 0, n_fail = 0, seed = 0, exp_n = 1, cyc = 0;
  int done_cnt = 0, last_we_cyc = -10, crst_cnt = 0, sns_cnt = 0;
  bit arst_seen = 0, prev_d = 0, prev_s = 0, finished = 0;
  item_t exp_q[$];

  function automatic bit ridge(int s, int c, int r);
    case (s)
      0: return ((c + r) % 3) == 0;
      1: return 1'b1;
      default: return r == (c % NR);
    endcase
  endfunction

  // 00 same, 01 pos valley/neg ridge, 10 pos ridge/neg valley
  function automatic logic [1:0] code(bit p, bit n);
    if (p == n) return 2'b00;
    return p ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // comparator model follows the rows the block selects
  always_comb begin
    for (int k = 0; k < NI; k++)
      cmp[2*k +: 2] = code(ridge(seed, int'(col), int'(prow[k*RW +: RW])),
                           ridge(seed, int'(col), int'(nrow[k*RW +: RW])));
  end

  task automatic push_frame(int n, int s);
    item_t it;
    seed  = s;
    exp_n = (n == 0) ? 1 : n;
    for (int c = 0; c < NC; c++)
      for (int p = 0; p < 2; p++) begin
        it.bank = p[0];
        it.col  = CW'(c);
        for (int k = 0; k < NI; k++) begin
          int pr = p ? 2 * k + 1 : 2 * k;                       // R4 / R5
          int nr = p ? ((k == NI - 1) ? 0 : 2 * k + 2) : 2 * k + 1;
          it.data[2*k +: 2] = code(ridge(s, c, pr), ridge(s, c, nr));
        end
        exp_q.push_back(it);
      end
  endtask

  task automatic run_frame(int n, int s, bit disturb);
    int d0 = done_cnt;
    push_frame(n, s);
    @(negedge clk);
    icnt  = 4'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (20) @(negedge clk);
      start = 1'b1;               // R11
      icnt  = 4'd2;               // R12
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 queue empty", exp_q.size(), 0);
    chk(!busy, "R10 idle after frame", busy, 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      chk(!(drv && sns), "R8 overlap", drv, 0);
      if (sns) chk(!prev_d, "R8 drive->sense gap", prev_d, 0);
      if (drv) chk(!prev_s, "R8 sense->drive gap", prev_s, 0);
      if (drv) chk(!cal, "R7 calib in drive", cal, 0);
      if (sns) chk(cal, "R7 calib in sense", cal, 1);
      if (cell_rst) crst_cnt++;
      if (arst) begin
        arst_seen = 1;
        sns_cnt = 0;
        if (col == 0 && !psel) chk(crst_cnt == CR, "R2 cell reset length", crst_cnt, CR);
      end
      if (drv) begin
        chk(arst_seen, "R6 amp reset before drive", arst_seen, 1);
        chk(!cell_rst, "R2 drive after cell reset", cell_rst, 0);
      end
      if (sns) sns_cnt++;
      if (we) begin
        item_t e, a;
        a = '{bank: bank, col: mcol, data: mdata};
        chk(prev_s, "R9 write one cycle after sense", prev_s, 1);
        chk(sns_cnt == exp_n, "R6 R12 sense steps", sns_cnt, exp_n);
        if (exp_q.size() == 0) chk(0, "R11 unexpected write", int'(a), -1);
        else begin
          e = exp_q.pop_front();
          chk(a.bank == e.bank, "R3 bank order", a.bank, e.bank);
          chk(a.col == e.col, "R3 column order", a.col, e.col);
          chk(a.data == e.data, "R4 R5 R9 codes", a.data, e.data);
        end
        arst_seen = 0;
        last_we_cyc = cyc;
      end
      if (done) begin
        done_cnt++;
        chk(last_we_cyc == cyc - 1, "R10 done after last write", cyc - last_we_cyc, 1);
        chk(exp_q.size() == 0, "R10 all writes done", exp_q.size(), 0);
        crst_cnt = 0;
      end
      prev_d = drv;
      prev_s = sns;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk({cell_rst, drv, sns, arst, cal, we, busy, done} == '0, "R1 controls idle",
        {cell_rst, drv, sns, arst, cal, we, busy, done}, 0);
    chk(col == '0 && !psel, "R1 col/pair idle", int'(col), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !cell_rst, "R1 idle after release", busy, 0);
    run_frame(5, 0, 0);
    run_frame(0, 1, 0);   // R6 zero count acts as one
    run_frame(7, 2, 1);
    run_frame(1, 0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule